// File: doc/BRIEF.md
# Carrier phase-reversal detector

This block watches a square-wave carrier that is sampled at eight times its own frequency by a free-running sample clock. It reports each 180-degree phase reversal as one clean, stretched pulse. The carrier arrives without any timing relation to the sample clock, so the block first brings it into the clock domain. It then compares every sample with the sample taken one full carrier period earlier. When the carrier keeps its phase, the two samples agree. After a reversal they disagree for a whole carrier period.

Small drift between the carrier and the sample clock makes a carrier edge land one sample early or late now and then. That gives a mismatch that lasts a single sample. A two-of-three pattern filter throws these away, and it keeps mismatches that show up in two adjacent samples or in samples two apart. The surviving strobes reload a retriggerable counter. The counter holds the phase-detect output high for a fixed number of sample clocks after the last strobe, so a burst of strobes becomes one pulse. A downstream decoder uses that pulse to recover the phase-modulated data.

Top module: `phase_flip_detector`

## Requirements
- R1: While `rst` is high at a clock edge, both `strobe_o` and `pulse_o` are low after that edge.
- R2: The first sample taken after a carrier reversal is the sample captured at edge k. `strobe_o` is first high after edge k+4 and `pulse_o` rises after edge k+5. This is a fixed latency of five sample clocks.
- R3: After reset, the comparison stays disabled until DELAY+2 edges have passed, so that the synchronizer and the delay line hold only real samples. A steady carrier applied from reset therefore never produces a strobe or a pulse.
- R4: A sample counts as a mismatch when it differs from the carrier sample captured DELAY edges earlier (DELAY defaults to 8, one carrier period).
- R5: A mismatch in two adjacent samples produces a strobe.
- R6: A mismatch in two samples two apart, with a matching sample between them, produces a strobe.
- R7: A mismatch lasting one isolated sample, with no other mismatch within two samples of it, never produces a strobe.
- R8: Each strobe drives `pulse_o` high from the next edge. `pulse_o` falls exactly STRETCH edges after the last strobe (STRETCH defaults to 8), and it never rises without a strobe.
- R9: A strobe that arrives while `pulse_o` is still high restarts the count, which lengthens the single pulse without a gap.
- R10: Each isolated carrier reversal yields exactly one rising edge on `pulse_o`. A carrier that only slips or gains one sample yields none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, eight times the carrier frequency |
| rst | input | 1 | Synchronous reset, active high |
| carrier_i | input | 1 | Square-wave carrier, asynchronous to `clk` |
| strobe_o | output | 1 | Filtered mismatch strobe |
| pulse_o | output | 1 | Stretched phase-detect pulse |

## Verification
A fault in the delay line or in the fill counter shows up at the ports as strobes during a steady carrier, either right after reset or one carrier period after any sample. That becomes visible within DELAY+5 clocks. A fault in the filter taps lets a one-sample slip through to `strobe_o`, or drops the strobe for a two-apart pattern, within four clocks of the mismatch. A fault in the stretch counter moves the falling edge of `pulse_o` away from STRETCH clocks after the last strobe. The bench compares both outputs against a behavioural model on every clock, so each of these faults is caught in the cycle where it first appears.

// File: rtl/phase_flip_detector.sv
module phase_flip_detector #(
  parameter int DELAY   = 8,
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic carrier_i,
  output logic strobe_o,
  output logic pulse_o
);
  localparam int FILL = DELAY + 2;
  localparam int FW   = $clog2(FILL + 1);
  localparam int CW   = $clog2(STRETCH + 1);

  logic [1:0]       sync_q;
  logic [DELAY-1:0] line_q;
  logic [FW-1:0]    fill_q;
  logic             mis_q, tap1_q, tap2_q, pair_q, skip_q;
  logic [CW-1:0]    cnt_q;

  wire smp   = sync_q[1];
  wire old   = line_q[DELAY-1];
  wire ready = (fill_q == FW'(FILL));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      line_q <= '0;
      fill_q <= '0;
      mis_q  <= 1'b0;
      tap1_q <= 1'b0;
      tap2_q <= 1'b0;
      pair_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], carrier_i};
      line_q <= {line_q[DELAY-2:0], smp};
      if (!ready) fill_q <= fill_q + 1'b1;
      mis_q  <= ready & (smp ^ old);
      tap1_q <= mis_q;
      tap2_q <= tap1_q;
      pair_q <= mis_q & tap1_q;
      skip_q <= mis_q & tap2_q;
    end
  end

  assign strobe_o = pair_q | skip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (strobe_o) begin
      cnt_q   <= '0;
      pulse_o <= 1'b1;
    end else if (pulse_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(STRETCH - 1)) pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/phase_flip_detector_chk.sv
module phase_flip_detector_chk #(
  parameter int DELAY   = 8,
  parameter int STRETCH = 8
) (
  input logic clk,
  input logic rst,
  input logic mis_i,
  input logic strobe_o,
  input logic pulse_o
);
  logic        seen;
  int unsigned gap;
  int unsigned age;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      gap  <= 0;
      age  <= 0;
    end else begin
      if (age < DELAY + 4) age <= age + 1;
      if (strobe_o) begin
        seen <= 1'b1;
        gap  <= 0;
      end else if (gap < STRETCH) gap <= gap + 1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!strobe_o && !pulse_o)); // R1
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst) (age < DELAY + 2) |-> !mis_i); // R3
  AST_TWO_OF_THREE: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> ($past(mis_i) && ($past(mis_i, 2) || $past(mis_i, 3)))); // R7
  AST_STRETCH_SPAN: assert property (@(posedge clk) disable iff (rst)
    pulse_o == (seen && gap < STRETCH)); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(pulse_o) |-> $past(strobe_o)); // R8
  AST_RETRIGGER: assert property (@(posedge clk) disable iff (rst) strobe_o |=> pulse_o); // R9
endmodule

bind phase_flip_detector phase_flip_detector_chk #(.DELAY(DELAY), .STRETCH(STRETCH)) chk (
  .clk(clk), .rst(rst), .mis_i(mis_q), .strobe_o(strobe_o), .pulse_o(pulse_o)
);

// File: tb/phase_flip_detector_test.sv
module phase_flip_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;
  localparam int S = 8;
  localparam int NMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carrier = 1'b0;
  logic strobe_o, pulse_o;

  phase_flip_detector #(.DELAY(D), .STRETCH(S)) uut (
    .clk(clk), .rst(rst), .carrier_i(carrier), .strobe_o(strobe_o), .pulse_o(pulse_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  int j = 0;
  bit h [NMAX];
  bit mm [NMAX];
  int rem = 0;
  bit prev_strobe = 0;
  bit last_pulse = 0;
  int rises = 0, rise_j = -1;
  int ph = 0;
  bit inv = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at sample %0d: actual=%0d expected=%0d", req, j, act, exp);
    end
  endtask

  // one sample clock: drive at the falling edge, compare a quarter period after the rising edge
  task automatic drive(input bit b);
    bit es, ep;
    @(negedge clk) carrier = b;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    j++;
    if (j >= NMAX) j = NMAX - 1;
    h[j] = b;
    mm[j] = (j - 2 - D >= 1) ? (h[j-2] != h[j-2-D]) : 1'b0;          // R4
    es = (j >= 4) ? (mm[j-1] && (mm[j-2] || mm[j-3])) : 1'b0;         // R5 R6 R7
    if (prev_strobe) rem = S; else if (rem > 0) rem--;                // R8 R9
    ep = (rem > 0);
    prev_strobe = es;
    check(strobe_o == es, "R5 strobe", strobe_o, es);
    check(pulse_o == ep, "R8 pulse", pulse_o, ep);
    if (pulse_o && !last_pulse) begin
      rises++;
      rise_j = j;
    end
    last_pulse = pulse_o;
  endtask

  task automatic gen(input int n);
    for (int i = 0; i < n; i++) begin
      drive(bit'((ph < 4) ^ inv));
      ph = (ph + 1) % 8;
    end
  endtask

  task automatic seg_end(input int exp, input string req);
    check(rises == exp, req, rises, exp);
    rises = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int fj;
    repeat (4) @(posedge clk);
    #(CLK_PERIOD / 4);
    check(strobe_o == 0 && pulse_o == 0, "R1 reset", {strobe_o, pulse_o}, 0);
    @(negedge clk) rst = 1'b0;

    // R3: steady carrier from reset, nothing reported
    gen(120);
    seg_end(0, "R3 fill quiet");

    // R2 R10: isolated reversals
    for (int f = 0; f < 4; f++) begin
      inv = ~inv;
      fj = j + 1;
      rise_j = -1;
      gen(63);
      seg_end(1, "R10 one pulse per reversal");
      check(rise_j - fj == 5, "R2 latency", rise_j - fj, 5);
    end

    // R7 R10: one-sample slips and gains
    for (int f = 0; f < 3; f++) begin
      ph = (ph + 7) % 8;
      gen(40);
      ph = (ph + 1) % 8;
      gen(40);
    end
    seg_end(0, "R7 jitter rejected");

    // R9: second reversal inside the pulse
    inv = ~inv;
    gen(10);
    inv = ~inv;
    gen(60);
    seg_end(1, "R9 retrigger single pulse");

    // flat carrier, settle
    for (int i = 0; i < 40; i++) drive(1'b0);
    rises = 0;

    // R7: one isolated mismatching sample
    drive(1'b1);
    for (int i = 0; i < 40; i++) drive(1'b0);
    seg_end(0, "R7 isolated");

    // R5: two adjacent mismatching samples
    drive(1'b1); drive(1'b1);
    for (int i = 0; i < 40; i++) drive(1'b0);
    seg_end(1, "R5 adjacent");

    // R6: mismatches two samples apart
    drive(1'b1); drive(1'b0); drive(1'b1);
    for (int i = 0; i < 40; i++) drive(1'b0);
    seg_end(1, "R6 two apart");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule